// File: doc/BRIEF.md
# Configurable Two-Five Decade Divider

This block is a four-bit event counter built from two small stages. The two-state stage is the single bit Q0, and it flips on each advance. The five-state stage holds Q3..Q1 and steps through five binary states. Each stage has its own one-cycle advance strobe, sampled on the rising edge of the one system clock. A falling edge of a stage clock in a ripple implementation maps to one strobe pulse here.

A two-bit mode input selects how the stages are linked. In split mode the stages run apart, each from its own strobe. In decimal mode strobe A drives Q0, and Q0 dropping from 1 to 0 carries into the five-state stage, so Q3..Q0 counts 0 to 9 in 8-4-2-1 code. In square-wave mode strobe B drives the five-state stage, and Q3 dropping carries into Q0. Q0 is then a divide-by-ten output with equal low and high halves. A carry takes effect in the same clock cycle as the strobe that causes it, so no intermediate states appear on the outputs.

Top module: `dd_two_five_divider`

## Requirements
- R1: In split mode (mode_sel 00) each cycle with step_a high inverts Q0, and Q0 holds in cycles with step_a low.
- R2: The five-state stage holds a binary value on Q3..Q1 with weights Q3=4, Q2=2, Q1=1. Each advance moves it through 0,1,2,3,4, and the advance after 4 returns it to 0. In split mode that advance is step_b.
- R3: mode_sel 11 behaves exactly like 00. Both stages may advance in the same cycle without affecting each other.
- R4: In decimal mode (mode_sel 01), after k step_a pulses from reset the value q[3:0] equals k mod 10 as a binary number. step_b has no effect in this mode.
- R5: In square-wave mode (mode_sel 10), after k step_b pulses from reset, let m = k mod 10. Q3..Q1 equals m mod 5, and Q0 is 0 for m of 0 to 4 and 1 for m of 5 to 9. step_a has no effect in this mode.
- R6: When the five-state stage advances at a constant rate, Q3 is high for exactly one state in every five.
- R7: rst is active high and synchronous. At the first rising clock edge with rst high, q becomes 0000. While rst stays high, q stays at 0000 and strobes are ignored. After release, counting restarts from 0.
- R8: Each strobe sampled high at a rising edge updates q at that same edge, including any carry into the other stage. Strobes high on consecutive cycles each count once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of both stages |
| mode_sel | input | 2 | 00/11 split, 01 decimal, 10 square-wave |
| step_a | input | 1 | Advance strobe for the two-state stage |
| step_b | input | 1 | Advance strobe for the five-state stage |
| q | output | 4 | Counter state, q[3:1] five-state stage, q[0] two-state stage |

## Verification
The outputs are the state registers themselves, so a wrong next-state value is visible on q in the cycle right after the strobe that caused it. A missing or misplaced carry between the stages cannot be seen until the feeding stage wraps. That takes at most two strobes in decimal mode and five in square-wave mode. A full decade in each linked mode therefore exposes any cascade fault within ten strobes. A fault in how reset or an ignored strobe is gated shows at the first edge where that input is active.

// File: rtl/dd_pkg.sv
package dd_pkg;

    // Five-state stage parameters
    localparam int QUINT_MOD = 5;
    localparam int QUINT_W   = $clog2(QUINT_MOD);
    localparam int OUT_W     = QUINT_W + 1;

    typedef enum logic [1:0] {
        MODE_SPLIT     = 2'b00,
        MODE_DECIMAL   = 2'b01,
        MODE_SQUARE    = 2'b10,
        MODE_SPLIT_ALT = 2'b11
    } dd_mode_e;

    // Per-stage advance enables for one clock cycle
    typedef struct packed {
        logic pair;
        logic quint;
    } dd_adv_t;

    // Packed so that quint lands on Q3..Q1 and pair on Q0
    typedef struct packed {
        logic [QUINT_W-1:0] quint;
        logic               pair;
    } dd_state_t;

    // Map the raw select onto the three behaviours; 11 folds onto split
    function automatic dd_mode_e decode_mode(input logic [1:0] raw);
        dd_mode_e m;
        case (raw)
            2'b01:   m = MODE_DECIMAL;
            2'b10:   m = MODE_SQUARE;
            default: m = MODE_SPLIT;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dd_pair_stage.sv
module dd_pair_stage (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_q,
    output logic at_top
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else if (adv) begin
            bit_q <= ~bit_q;
        end
    end

    // A set bit means the next advance produces a 1-to-0 transition
    assign at_top = bit_q;

    p_pair_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        adv |=> (bit_q != $past(bit_q)));

    p_pair_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(bit_q));

endmodule

// File: rtl/dd_quint_stage.sv
module dd_quint_stage #(
    parameter int MOD = dd_pkg::QUINT_MOD,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         at_top
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] count_nxt;

    always_comb begin
        count_nxt = count;
        if (adv) begin
            count_nxt = (count == LAST) ? '0 : count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

    assign at_top = (count == LAST);

    p_quint_range_r2: assert property (@(posedge clk) disable iff (rst)
        count <= LAST);

    p_quint_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && count == LAST) |=> (count == '0));

    p_quint_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && count != LAST) |=> (count == $past(count) + 1'b1));

    p_quint_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(count));

endmodule

// File: rtl/dd_advance_router.sv
module dd_advance_router
    import dd_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       step_a,
    input  logic       step_b,
    input  logic       pair_top,
    input  logic       quint_top,
    output dd_adv_t    adv
);

    dd_mode_e mode;

    assign mode = decode_mode(mode_sel);

    // Carries are taken from the current state, so a cascaded stage
    // moves in the same cycle as the stage feeding it
    always_comb begin
        adv = '0;
        case (mode)
            MODE_DECIMAL: begin
                adv.pair  = step_a;
                adv.quint = step_a & pair_top;
            end
            MODE_SQUARE: begin
                adv.quint = step_b;
                adv.pair  = step_b & quint_top;
            end
            default: begin
                adv.pair  = step_a;
                adv.quint = step_b;
            end
        endcase
    end

endmodule

// File: rtl/dd_two_five_divider.sv
module dd_two_five_divider
    import dd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             step_a,
    input  logic             step_b,
    output logic [OUT_W-1:0] q
);

    dd_adv_t   adv;
    dd_state_t st;
    logic      pair_top;
    logic      quint_top;

    dd_advance_router u_router (
        .mode_sel  (mode_sel),
        .step_a    (step_a),
        .step_b    (step_b),
        .pair_top  (pair_top),
        .quint_top (quint_top),
        .adv       (adv)
    );

    dd_pair_stage u_pair (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv.pair),
        .bit_q  (st.pair),
        .at_top (pair_top)
    );

    dd_quint_stage #(
        .MOD (QUINT_MOD),
        .W   (QUINT_W)
    ) u_quint (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv.quint),
        .count  (st.quint),
        .at_top (quint_top)
    );

    assign q = st;

    // Port-level checks
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (q == '0));

    p_decimal_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && step_a && q[0]) |=>
        (!q[0] && q[OUT_W-1:1] != $past(q[OUT_W-1:1])));

    p_decimal_ignore_b_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && !step_a) |=> $stable(q));

    p_square_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10 && step_b && q[OUT_W-1]) |=>
        (q[OUT_W-1:1] == '0 && q[0] != $past(q[0])));

    p_square_ignore_a_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10 && !step_b) |=> $stable(q));

    p_split_isolation_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[1] == mode_sel[0] && !step_b) |=> $stable(q[OUT_W-1:1]));

endmodule

// File: tb/dd_two_five_divider_bench.sv
module dd_two_five_divider_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       step_a = 1'b0;
    logic       step_b = 1'b0;
    logic [3:0] q;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dd_two_five_divider u_dd_two_five_divider (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .step_a   (step_a),
        .step_b   (step_b),
        .q        (q)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, sample shortly after rising edge
    task automatic cyc(input logic a, input logic b);
        @(negedge clk);
        step_a = a;
        step_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1;
        mode_sel = m;
        cyc(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [3:0] exp_decimal(input int k);
        return 4'(k % 10);
    endfunction

    function automatic logic [3:0] exp_square(input int k);
        int m = k % 10;
        return {3'(m % 5), (m >= 5) ? 1'b1 : 1'b0};
    endfunction

    task automatic t_reset_state;
        // R7: strobes held high during reset are ignored
        @(negedge clk);
        rst = 1'b1;
        mode_sel = 2'b00;
        cyc(1'b1, 1'b1);
        chk("R7 reset clears", q, 4'b0000);
        cyc(1'b1, 1'b1);
        chk("R7 strobes ignored in reset", q, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        step_a = 1'b0;
        step_b = 1'b0;
        cyc(1'b0, 1'b0);
        chk("R7 idle after release", q, 4'b0000);
    endtask

    task automatic t_split(input logic [1:0] m, input string tag);
        int ka = 0;
        int kb = 0;
        do_reset(m);
        for (int i = 0; i < 12; i++) begin
            logic a = (i % 3) != 1;
            logic b = (i % 2) == 0;
            int q3_hi = 0;
            cyc(a, b);
            if (a) ka++;
            if (b) kb++;
            chk({tag, " R1/R2 split step"}, q, {3'(kb % 5), 1'(ka % 2)});
            if (i == 11) q3_hi = 0;
        end
        // R2, R6: Q3 duty over 10 constant-rate B advances
        begin
            int hi = 0;
            for (int i = 0; i < 10; i++) begin
                cyc(1'b0, 1'b1);
                kb++;
                if (q[3]) hi++;
            end
            checks++;
            if (hi != 2) begin
                errors++;
                $display("FAIL R6 Q3 high states actual=%0d expected=2", hi);
            end
        end
        cyc(1'b0, 1'b0);
        chk({tag, " R1 hold no strobe"}, q, {3'(kb % 5), 1'(ka % 2)});
    endtask

    task automatic t_decimal;
        int k = 0;
        do_reset(2'b01);
        for (int i = 0; i < 23; i++) begin
            cyc(1'b1, 1'b0);
            k++;
            chk("R4 decimal count", q, exp_decimal(k));
            cyc(1'b0, 1'b1);
            chk("R4 step_b ignored", q, exp_decimal(k));
        end
    endtask

    task automatic t_square;
        int k = 0;
        do_reset(2'b10);
        for (int i = 0; i < 23; i++) begin
            cyc(1'b0, 1'b1);
            k++;
            chk("R5 square count", q, exp_square(k));
            cyc(1'b1, 1'b0);
            chk("R5 step_a ignored", q, exp_square(k));
        end
    endtask

    task automatic t_back_to_back;
        int k = 0;
        // R8: strobe held high for consecutive cycles in decimal mode
        do_reset(2'b01);
        for (int i = 0; i < 14; i++) begin
            cyc(1'b1, 1'b0);
            k++;
            chk("R8 decimal back-to-back", q, exp_decimal(k));
        end
        k = 0;
        do_reset(2'b10);
        for (int i = 0; i < 14; i++) begin
            cyc(1'b0, 1'b1);
            k++;
            chk("R8 square back-to-back", q, exp_square(k));
        end
        cyc(1'b0, 1'b0);
    endtask

    task automatic t_reset_midcount;
        int k = 0;
        do_reset(2'b01);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b0);
            k++;
        end
        chk("R4 before mid reset", q, exp_decimal(k));
        @(negedge clk);
        rst = 1'b1;
        cyc(1'b1, 1'b0);
        chk("R7 mid-count reset", q, 4'b0000);
        cyc(1'b1, 1'b1);
        chk("R7 held reset ignores strobes", q, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        step_a = 1'b0;
        k = 0;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0);
            k++;
        end
        chk("R7 restart from zero", q, exp_decimal(k));
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_split(2'b00, "R3 mode00");
        t_split(2'b11, "R3 mode11");
        t_decimal();
        t_square();
        t_back_to_back();
        t_reset_midcount();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule